// File: doc/BRIEF.md
# Dual-Ratio Fractional Clock Divider

This block takes a fast input clock and makes a slower divided clock whose average ratio need not be an integer. It has two integer divide lengths, A and B, and a repeat count for each. It emits a run of A-length periods, then a run of B-length periods, and then starts the same pattern again. The result is an average output frequency of f_in × (ma+mb) / (na·ma + nb·mb). When the mode pin selects single operation, only divide length A is used, and the B length and both repeat counts have no effect.

Every programmed field holds its count minus one. The block takes the fields and the mode into its working copy only at safe points: the end of a whole A+B sequence in dual operation, or the end of a period in single operation. A change made by the surrounding logic part-way through a sequence therefore never leaves a shortened period. Besides the divided clock, the block gives a one-cycle end-of-period strobe that can serve as a clock enable, and a flag that shows which divide length the current period uses.

Top module: `fracdiv_dual`

## Requirements
- R1: While `rst_ni` is low, `div_clk_o`, `tick_o` and `phase_b_o` are all 0. Reset is asynchronous.
- R2: Each field holds its count minus one. A field value k means a length or count of k+1, so 0 means 1.
- R3: When `dual_i`=0 is in effect, every period lasts na input cycles and `phase_b_o` stays 0. `div_b_i`, `rep_a_i` and `rep_b_i` have no effect.
- R4: When `dual_i`=1 is in effect, the block emits ma periods of na cycles with `phase_b_o`=0, then mb periods of nb cycles with `phase_b_o`=1, and repeats. `phase_b_o` changes only at a period boundary.
- R5: One full dual sequence spans exactly na·ma + nb·mb input cycles and contains ma+mb periods.
- R6: In each period of length n, `div_clk_o` is high for the first floor(n/2) cycles and low for the rest. When n=1 it is high for that whole cycle, so a run of divide-by-1 periods keeps it high.
- R7: `tick_o` is 1 in exactly the last input cycle of each period, and 0 in every other cycle.
- R8: New field and mode values take effect only at the next boundary of the configuration in force. In dual operation that boundary is the end of the last B period. In single operation it is the end of the current period. This holds for a switch between modes too.
- R9: After reset is released, one cycle passes with all outputs 0 while the settings are taken in. The first period, an A period, begins on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to divide |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dual_i | input | 1 | 1 = alternate A and B lengths, 0 = A length only |
| div_a_i | input | DIV_W | Divide length A, minus one |
| rep_a_i | input | REP_W | Repeat count for A periods, minus one |
| div_b_i | input | DIV_W | Divide length B, minus one |
| rep_b_i | input | REP_W | Repeat count for B periods, minus one |
| div_clk_o | output | 1 | Divided clock |
| tick_o | output | 1 | High in the last input cycle of each period |
| phase_b_o | output | 1 | 1 while the current period uses length B |

## Verification
Single mode is swept over lengths 1 to 6, with varied B fields, to show that only length A matters and to check the high-time rule at odd, even and unit lengths. Dual mode is swept over every mix of lengths 1 to 4 and repeat counts 1 to 3. This exposes swapped counters, off-by-one repeat counts and wrong total sequence lengths. Settings are also changed mid-sequence, from single to dual, and from dual to single, to show that each change lands only at the proper boundary. A reset during a run checks that the outputs drop at once.

// File: rtl/fracdiv_pkg.sv
package fracdiv_pkg;
  localparam int unsigned FD_DIV_W = 12;
  localparam int unsigned FD_REP_W = 12;
  typedef enum logic {PH_A = 1'b0, PH_B = 1'b1} fd_phase_e;
endpackage

// File: rtl/fracdiv_cfg_hold.sv
// Working copy of the settings. Takes a new copy on load_i and gives
// decoded counts (field + 1).
module fracdiv_cfg_hold #(
  parameter int unsigned DIV_W = 12,
  parameter int unsigned REP_W = 12,
  localparam int unsigned LEN_W = DIV_W + 1,
  localparam int unsigned CNT_W = REP_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             dual_i,
  input  logic [DIV_W-1:0] na_i,
  input  logic [REP_W-1:0] ma_i,
  input  logic [DIV_W-1:0] nb_i,
  input  logic [REP_W-1:0] mb_i,
  output logic             dual_o,
  output logic [LEN_W-1:0] na_o,
  output logic [CNT_W-1:0] ma_o,
  output logic [LEN_W-1:0] nb_o,
  output logic [CNT_W-1:0] mb_o
);
  logic             dual_q;
  logic [DIV_W-1:0] na_q, nb_q;
  logic [REP_W-1:0] ma_q, mb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dual_q <= 1'b0;
      na_q   <= '0;
      ma_q   <= '0;
      nb_q   <= '0;
      mb_q   <= '0;
    end else if (load_i) begin
      dual_q <= dual_i;
      na_q   <= na_i;
      ma_q   <= ma_i;
      nb_q   <= nb_i;
      mb_q   <= mb_i;
    end
  end

  assign dual_o = dual_q;
  assign na_o   = {1'b0, na_q} + LEN_W'(1);
  assign nb_o   = {1'b0, nb_q} + LEN_W'(1);
  assign ma_o   = {1'b0, ma_q} + CNT_W'(1);
  assign mb_o   = {1'b0, mb_q} + CNT_W'(1);
endmodule

// File: rtl/fracdiv_period_cnt.sv
// Counts input cycles inside one output period and shapes the high time.
module fracdiv_period_cnt #(
  parameter int unsigned LEN_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] pos_o,
  output logic             last_o,
  output logic             high_o
);
  logic [LEN_W-1:0] pos_q;
  logic [LEN_W-1:0] hi_len;

  assign hi_len = (len_i == LEN_W'(1)) ? LEN_W'(1) : (len_i >> 1);
  assign last_o = run_i && (pos_q == len_i - LEN_W'(1));
  assign high_o = run_i && (pos_q < hi_len);
  assign pos_o  = pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pos_q <= '0;
    else if (!run_i)      pos_q <= '0;
    else if (last_o)      pos_q <= '0;
    else                  pos_q <= pos_q + LEN_W'(1);
  end
endmodule

// File: rtl/fracdiv_rep_cnt.sv
// Counts the periods spent in one phase; done_o marks the last repeat.
module fracdiv_rep_cnt #(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = (cnt_q == lim_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step_i)  cnt_q <= done_o ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/fracdiv_dual.sv
module fracdiv_dual
  import fracdiv_pkg::*;
#(
  parameter int unsigned DIV_W = FD_DIV_W,
  parameter int unsigned REP_W = FD_REP_W,
  localparam int unsigned LEN_W = DIV_W + 1,
  localparam int unsigned CNT_W = REP_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dual_i,
  input  logic [DIV_W-1:0] div_a_i,
  input  logic [REP_W-1:0] rep_a_i,
  input  logic [DIV_W-1:0] div_b_i,
  input  logic [REP_W-1:0] rep_b_i,
  output logic             div_clk_o,
  output logic             tick_o,
  output logic             phase_b_o
);
  logic             run_q;
  fd_phase_e        phase_q;
  logic             act_dual;
  logic [LEN_W-1:0] act_na, act_nb, n_cur, pos;
  logic [CNT_W-1:0] act_ma, act_mb;
  logic [CNT_W-1:0] lim [2];
  logic [1:0]       rep_done, rep_step;
  logic             per_end, boundary, load;

  assign n_cur    = (phase_q == PH_B) ? act_nb : act_na;
  assign boundary = per_end && (!act_dual || (phase_q == PH_B && rep_done[1]));
  assign load     = !run_q || boundary;

  fracdiv_cfg_hold #(.DIV_W(DIV_W), .REP_W(REP_W)) u_cfg (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(load),
    .dual_i(dual_i), .na_i(div_a_i), .ma_i(rep_a_i),
    .nb_i  (div_b_i), .mb_i(rep_b_i),
    .dual_o(act_dual), .na_o(act_na), .ma_o(act_ma),
    .nb_o  (act_nb), .mb_o(act_mb)
  );

  fracdiv_period_cnt #(.LEN_W(LEN_W)) u_per (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(run_q), .len_i(n_cur),
    .pos_o (pos), .last_o(per_end), .high_o(div_clk_o)
  );

  assign lim[0] = act_ma;
  assign lim[1] = act_mb;

  for (genvar gi = 0; gi < 2; gi++) begin : g_rep
    assign rep_step[gi] = per_end && act_dual &&
                          ((phase_q == PH_B) == (gi == 1));
    fracdiv_rep_cnt #(.CNT_W(CNT_W)) u_rep (
      .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(load),
      .step_i(rep_step[gi]), .lim_i(lim[gi]), .done_o(rep_done[gi])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      phase_q <= PH_A;
    end else begin
      run_q <= 1'b1;
      if (load) begin
        phase_q <= PH_A;
      end else if (per_end && act_dual) begin
        if (phase_q == PH_A && rep_done[0]) phase_q <= PH_B;
      end
    end
  end

  assign tick_o    = per_end;
  assign phase_b_o = (phase_q == PH_B);
endmodule

// File: rtl/fracdiv_dual_chk.sv
module fracdiv_dual_chk #(
  parameter int unsigned DIV_W = 12,
  parameter int unsigned REP_W = 12,
  localparam int unsigned LEN_W = DIV_W + 1,
  localparam int unsigned CNT_W = REP_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             div_clk_o,
  input logic             tick_o,
  input logic             phase_b_o,
  input logic             run_q,
  input logic [LEN_W-1:0] pos,
  input logic [LEN_W-1:0] n_cur,
  input logic             act_dual,
  input logic [LEN_W-1:0] act_na,
  input logic [LEN_W-1:0] act_nb,
  input logic [CNT_W-1:0] act_ma,
  input logic [CNT_W-1:0] act_mb
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!div_clk_o && !tick_o && !phase_b_o); // R1
    end
  end

  AST_LOAD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (!div_clk_o && !tick_o && !phase_b_o)); // R9

  AST_SINGLE_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !act_dual) |-> !phase_b_o); // R3

  AST_PHASE_AT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_q) && !$past(tick_o)) |-> $stable(phase_b_o)); // R4

  AST_RISE_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_clk_o) |-> (pos == '0)); // R6

  AST_LAST_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && n_cur > LEN_W'(1)) |-> !div_clk_o); // R6

  AST_POS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (pos < n_cur)); // R7

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_q) && !$past(tick_o)) |->
      $stable({act_dual, act_na, act_nb, act_ma, act_mb})); // R8
endmodule

bind fracdiv_dual fracdiv_dual_chk #(.DIV_W(DIV_W), .REP_W(REP_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .div_clk_o(div_clk_o), .tick_o(tick_o),
  .phase_b_o(phase_b_o), .run_q(run_q), .pos(pos), .n_cur(n_cur),
  .act_dual(act_dual), .act_na(act_na), .act_nb(act_nb),
  .act_ma(act_ma), .act_mb(act_mb)
);

// File: tb/test_fracdiv_dual.sv
`timescale 1ns/1ps
module test_fracdiv_dual;
  localparam int DW = 12;
  localparam int RW = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic dual = 1'b0;
  logic [DW-1:0] na_f = '0, nb_f = '0;
  logic [RW-1:0] ma_f = '0, mb_f = '0;
  logic div_clk, tick, phase_b;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit hung = 1'b0;
  int exp_len[$];
  int exp_ph[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  fracdiv_dual #(.DIV_W(DW), .REP_W(RW)) i_fracdiv_dual (
    .clk_i(clk), .rst_ni(rst_ni), .dual_i(dual),
    .div_a_i(na_f), .rep_a_i(ma_f), .div_b_i(nb_f), .rep_b_i(mb_f),
    .div_clk_o(div_clk), .tick_o(tick), .phase_b_o(phase_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // R2: fields are driven as count minus one
  task automatic set_cfg(input bit d, input int na, input int ma, input int nb, input int mb);
    dual = d;
    na_f = DW'(na - 1);
    ma_f = RW'(ma - 1);
    nb_f = DW'(nb - 1);
    mb_f = RW'(mb - 1);
  endtask

  task automatic push_seq(input bit d, input int na, input int ma, input int nb, input int mb);
    if (!d) begin
      exp_len.push_back(na); exp_ph.push_back(0);
    end else begin
      for (int i = 0; i < ma; i++) begin exp_len.push_back(na); exp_ph.push_back(0); end
      for (int i = 0; i < mb; i++) begin exp_len.push_back(nb); exp_ph.push_back(1); end
    end
  endtask

  // reset, hold, release; checks R1 during reset and R9 in the load cycle
  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(!div_clk && !tick && !phase_b, "R1 outputs low in reset",
        {29'd0, div_clk, tick, phase_b}, 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk(!div_clk && !tick && !phase_b, "R9 load cycle quiet",
        {29'd0, div_clk, tick, phase_b}, 0);
  endtask

  // consumes k periods from the expected queues, returns cycles spent
  task automatic consume(input int k, output int spent);
    spent = 0;
    for (int p = 0; p < k; p++) begin
      int el, eph, eh, len, highs, badpos, badph, badtk;
      bit seen_low;
      el = exp_len.pop_front();
      eph = exp_ph.pop_front();
      eh = (el == 1) ? 1 : el / 2;
      len = 0; highs = 0; badpos = 0; badph = 0; badtk = 0; seen_low = 0;
      do begin
        @(negedge clk);
        len++;
        if (div_clk) begin highs++; if (seen_low) badpos++; end
        else seen_low = 1;
        if (int'(phase_b) != eph) badph++;
        if (tick && len != el) badtk++;
        if (len > 5000) begin hung = 1'b1; break; end
      end while (!tick);
      spent += len;
      chk(len == el, eph ? "R4 period length B" : "R3 R4 period length A", len, el);
      chk(highs == eh && badpos == 0, "R6 high time", highs, eh);
      chk(badph == 0, "R4 phase flag", badph, 0);
      chk(badtk == 0, "R7 tick position", badtk, 0);
      if (hung) break;
    end
  endtask

  initial begin : wd
    wait (cycles > 150000);
    hung = 1'b1;
  end

  initial begin : main
    int sp;
    // single mode sweep, B fields varied (R3)
    for (int n = 1; n <= 6 && !hung; n++) begin
      set_cfg(0, n, 1 + n % 3, 7 - n, 2 + n);
      do_reset();
      for (int j = 0; j < 3; j++) push_seq(0, n, 1, 0, 0);
      consume(3, sp);
      chk(sp == 3 * n, "R3 single total", sp, 3 * n);
    end
    // dual sweep (R4, R5)
    for (int na = 1; na <= 4; na++)
      for (int nb = 1; nb <= 4; nb++)
        for (int ma = 1; ma <= 3; ma++)
          for (int mb = 1; mb <= 3 && !hung; mb++) begin
            set_cfg(1, na, ma, nb, mb);
            do_reset();
            push_seq(1, na, ma, nb, mb);
            push_seq(1, na, ma, nb, mb);
            consume(ma + mb, sp);
            chk(sp == na * ma + nb * mb, "R5 sequence span", sp, na * ma + nb * mb);
            consume(ma + mb, sp);
            chk(sp == na * ma + nb * mb, "R5 second sequence span", sp, na * ma + nb * mb);
          end
    // R8: mid-sequence change waits for sequence end
    set_cfg(1, 3, 3, 5, 2);
    do_reset();
    push_seq(1, 3, 3, 5, 2);
    consume(1, sp);
    set_cfg(1, 2, 1, 4, 2);
    push_seq(1, 2, 1, 4, 2);
    push_seq(1, 2, 1, 4, 2);
    consume(4 + 6, sp);
    // R8: single to dual at period end
    set_cfg(0, 3, 1, 1, 1);
    do_reset();
    push_seq(0, 3, 1, 1, 1);
    push_seq(0, 3, 1, 1, 1);
    consume(1, sp);
    consume(1, sp);
    set_cfg(1, 2, 2, 6, 1);
    push_seq(1, 2, 2, 6, 1);
    consume(3, sp);
    // R8: dual to single waits for sequence end
    set_cfg(1, 4, 2, 2, 2);
    do_reset();
    push_seq(1, 4, 2, 2, 2);
    consume(1, sp);
    set_cfg(0, 5, 3, 3, 3);
    push_seq(0, 5, 1, 0, 0);
    push_seq(0, 5, 1, 0, 0);
    consume(3 + 2, sp);
    // R1: reset mid-run drops outputs at once
    set_cfg(1, 1, 2, 3, 2);
    do_reset();
    push_seq(1, 1, 2, 3, 2);
    consume(3, sp);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(!div_clk && !tick && !phase_b, "R1 async reset mid-run",
        {29'd0, div_clk, tick, phase_b}, 0);
    exp_len.delete();
    exp_ph.delete();
    disable wd;
    if (hung) chk(0, "R7 watchdog", cycles, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : wd_end
    wait (hung);
    #1000;
    if (!(total == 0 && bad == 0)) begin
      chk(0, "R7 watchdog expired", cycles, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule